// File: doc/BRIEF.md
# Forward-Edge Landing Pad Checker

This block runs alongside an in-order integer pipeline and guards the forward edges of control flow. At every retirement it looks at the instruction's decoded class, its source and destination register indices, and the two low bits of its pc. For a landing-pad candidate it also looks at the 20-bit immediate. It receives the upper twenty bits of register x7 and the enable bit that belongs to the current privilege level.

The block holds a single bit of state. When that bit is set, the next retiring instruction must be a properly aligned landing pad. An indirect register jump sets the bit. A jump whose source is a link register or the guard register x7 is exempt and does not set it.

A failed landing is reported to trap logic one cycle after the offending instruction is presented. The report is a single-cycle pulse that carries the software-check cause and the landing-fault code.

Top module: `lp_guard`

## Requirements
- R1: After reset, `lpExpected` is 0 and `faultPulse` is 0.
- R2: Suppose a retiring, enabled instruction has class 1 (indirect register jump) and rs1 is not 1, 5 or 7. Then `lpExpected` reads 1 from the following cycle.
- R3: An indirect register jump with rs1 equal to 1 or 5 (a return) leaves `lpExpected` at 0.
- R4: An indirect register jump with rs1 equal to 7 (a software-guarded jump) leaves `lpExpected` at 0.
- R5: A landing pad is class 2 (upper-immediate-plus-pc opcode) with rd equal to 0. While `lpExpected` is 1, any other retiring instruction faults, including class 2 with a nonzero rd. A landing pad that retires while `lpExpected` is 0 has no effect.
- R6: While `lpExpected` is 1, a landing pad whose pc bits 1:0 are not zero faults.
- R7: While `lpExpected` is 1, a landing pad faults if its label is nonzero and differs from `x7Hi`. A landing pad with a zero label or a matching label passes, and `lpExpected` returns to 0.
- R8: A fault drives `faultPulse` high for the one cycle after the instruction is presented, with `faultCause` = 18 and `faultTval` = 2. Both fields read 0 when there is no fault. A faulting instruction leaves `lpExpected` at 1.
- R9: When `lpEnable` is 0, a retiring instruction never faults and never sets the state, and it clears `lpExpected` to 0.
- R10: An instruction presented with `instKill` high causes no fault and leaves `lpExpected` unchanged.
- R11: In a cycle with `instValid` low, no fault is raised and `lpExpected` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An instruction is presented for retirement |
| instKill | input | 1 | The presented instruction traps or is flushed and does not retire |
| instCls | input | 2 | Class: 0 other, 1 indirect register jump, 2 upper-immediate-plus-pc, 3 other |
| rs1Idx | input | 5 | Source register index |
| rdIdx | input | 5 | Destination register index |
| instPcLo | input | 2 | Bits 1:0 of the instruction's pc |
| lpLabel | input | 20 | Immediate field of a landing-pad candidate |
| x7Hi | input | 20 | Bits 31:12 of register x7 |
| lpEnable | input | 1 | Landing-pad enforcement enable for the current privilege level |
| lpExpected | output | 1 | Expectation state: 1 means a landing pad must come next |
| faultPulse | output | 1 | One-cycle software-check exception request |
| faultCause | output | 5 | Exception cause (18 on a fault) |
| faultTval | output | 32 | Trap value (2, landing fault, on a fault) |

## Verification
The bench probes the edges of the exemption set. A jump through x0 or x6 must arm the check, and a jump through x1, x5 or x7 must not. A design that compared only against the link registers would arm on x7 and then fault on a legitimate guarded switch table.

The landing-pad decode is tested with an upper-immediate-plus-pc instruction whose rd is nonzero. It is also tested with a misaligned but otherwise perfect pad, and with a zero label against an arbitrary x7. A checker that ignored rd or alignment would accept the pad. One that compared labels unconditionally would reject the zero-label pad.

After a fault, the bench confirms that the state stays armed. A killed jump and a killed non-pad instruction must not move the state. Dropping the enable must clear an armed state without raising a fault.

// File: rtl/lp_guard_pkg.sv
package lp_guard_pkg;

  typedef enum logic [1:0] {
    CLS_OTHER  = 2'd0,
    CLS_INDJMP = 2'd1,
    CLS_AUIPC  = 2'd2,
    CLS_RSVD   = 2'd3
  } instClass_t;

  // control -> datapath strobes
  typedef struct packed {
    logic retire;   // instruction really retires
    logic doCheck;  // enforcement active and a pad is required now
  } guardStrobe_t;

endpackage

// File: rtl/lp_guard_ctrl.sv
module lp_guard_ctrl
  import lp_guard_pkg::*;
#(
  parameter int REG_IDX_W = 5,
  parameter int LINK_A    = 1,
  parameter int LINK_B    = 5,
  parameter int GUARD_REG = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 instValid,
  input  logic                 instKill,
  input  logic                 lpEnable,
  input  instClass_t           instCls,
  input  logic [REG_IDX_W-1:0] rs1Idx,
  input  logic                 landFail,
  output guardStrobe_t         strobe,
  output logic                 lpExpected
);

  localparam logic [REG_IDX_W-1:0] LINK_A_IDX = REG_IDX_W'(LINK_A);
  localparam logic [REG_IDX_W-1:0] LINK_B_IDX = REG_IDX_W'(LINK_B);
  localparam logic [REG_IDX_W-1:0] GUARD_IDX  = REG_IDX_W'(GUARD_REG);

  logic expState;
  logic expNext;
  logic rs1Exempt;
  logic armReq;

  assign rs1Exempt = (rs1Idx == LINK_A_IDX) || (rs1Idx == LINK_B_IDX) ||
                     (rs1Idx == GUARD_IDX);
  assign armReq    = (instCls == CLS_INDJMP) && !rs1Exempt;

  assign strobe.retire  = instValid && !instKill;
  assign strobe.doCheck = strobe.retire && lpEnable && expState;

  always_comb begin
    expNext = expState;
    if (strobe.retire) begin
      if (!lpEnable)     expNext = 1'b0;
      else if (expState) expNext = landFail;
      else               expNext = armReq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) expState <= 1'b0;
    else       expState <= expNext;
  end

  assign lpExpected = expState;

  // R4
  guard_noset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !instKill && !expState && instCls == CLS_INDJMP &&
     rs1Idx == GUARD_IDX) |=> !lpExpected);

  // R3
  return_noset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !instKill && !expState && instCls == CLS_INDJMP &&
     (rs1Idx == LINK_A_IDX || rs1Idx == LINK_B_IDX)) |=> !lpExpected);

  // R10 R11
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(instValid && !instKill) |=> (lpExpected == $past(lpExpected)));

  // R9
  disabled_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !instKill && !lpEnable) |=> !lpExpected);

endmodule

// File: rtl/lp_guard_dpath.sv
module lp_guard_dpath
  import lp_guard_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_IDX_W = 5,
  parameter int LABEL_W   = 20,
  parameter int CAUSE_W   = 5,
  parameter int SW_CHECK_CAUSE = 18,
  parameter int LP_FAULT_CODE  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  guardStrobe_t         strobe,
  input  instClass_t           instCls,
  input  logic [REG_IDX_W-1:0] rdIdx,
  input  logic [1:0]           instPcLo,
  input  logic [LABEL_W-1:0]   lpLabel,
  input  logic [LABEL_W-1:0]   x7Hi,
  output logic                 landFail,
  output logic                 faultPulse,
  output logic [CAUSE_W-1:0]   faultCause,
  output logic [XLEN-1:0]      faultTval
);

  localparam logic [CAUSE_W-1:0] CAUSE_VAL = CAUSE_W'(SW_CHECK_CAUSE);
  localparam logic [XLEN-1:0]    TVAL_VAL  = XLEN'(LP_FAULT_CODE);

  logic isLpad;
  logic misAligned;
  logic labelBad;
  logic faultNow;

  assign isLpad     = (instCls == CLS_AUIPC) && (rdIdx == '0);
  assign misAligned = |instPcLo;
  assign labelBad   = (lpLabel != '0) && (lpLabel != x7Hi);
  assign landFail   = !isLpad || misAligned || labelBad;
  assign faultNow   = strobe.doCheck && landFail;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultPulse <= 1'b0;
      faultCause <= '0;
      faultTval  <= '0;
    end else begin
      faultPulse <= faultNow;
      faultCause <= faultNow ? CAUSE_VAL : '0;
      faultTval  <= faultNow ? TVAL_VAL  : '0;
    end
  end

  // R8
  fault_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> (faultCause == CAUSE_VAL && faultTval == TVAL_VAL));

  // R7
  clean_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doCheck && instCls == CLS_AUIPC && rdIdx == '0 &&
     instPcLo == 2'b00 && lpLabel == '0) |=> !faultPulse);

  // R11
  idle_nofault_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.retire |=> !faultPulse);

endmodule

// File: rtl/lp_guard.sv
module lp_guard
  import lp_guard_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_IDX_W = 5,
  parameter int LABEL_W   = 20,
  parameter int CAUSE_W   = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 instValid,
  input  logic                 instKill,
  input  logic [1:0]           instCls,
  input  logic [REG_IDX_W-1:0] rs1Idx,
  input  logic [REG_IDX_W-1:0] rdIdx,
  input  logic [1:0]           instPcLo,
  input  logic [LABEL_W-1:0]   lpLabel,
  input  logic [LABEL_W-1:0]   x7Hi,
  input  logic                 lpEnable,
  output logic                 lpExpected,
  output logic                 faultPulse,
  output logic [CAUSE_W-1:0]   faultCause,
  output logic [XLEN-1:0]      faultTval
);

  instClass_t   clsDec;
  guardStrobe_t strobe;
  logic         landFail;

  assign clsDec = instClass_t'(instCls);

  lp_guard_ctrl #(.REG_IDX_W(REG_IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instKill(instKill),
    .lpEnable(lpEnable), .instCls(clsDec), .rs1Idx(rs1Idx),
    .landFail(landFail), .strobe(strobe), .lpExpected(lpExpected)
  );

  lp_guard_dpath #(.XLEN(XLEN), .REG_IDX_W(REG_IDX_W), .LABEL_W(LABEL_W),
                   .CAUSE_W(CAUSE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .instCls(clsDec),
    .rdIdx(rdIdx), .instPcLo(instPcLo), .lpLabel(lpLabel), .x7Hi(x7Hi),
    .landFail(landFail), .faultPulse(faultPulse), .faultCause(faultCause),
    .faultTval(faultTval)
  );

  // R8
  fault_keeps_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> lpExpected);

endmodule

// File: tb/sim_lp_guard.sv
module sim_lp_guard;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0, instKill = 1'b0, lpEnable = 1'b1;
  logic [1:0]  instCls = 2'd0, instPcLo = 2'd0;
  logic [4:0]  rs1Idx = '0, rdIdx = '0;
  logic [19:0] lpLabel = '0, x7Hi = '0;
  logic        lpExpected, faultPulse;
  logic [4:0]  faultCause;
  logic [31:0] faultTval;

  int checks = 0;
  int errors = 0;
  bit refExp = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    bit    f;
    bit    e;
    string tag;
  } expItem_t;
  expItem_t q[$];

  always #4 clk = ~clk;

  lp_guard u0 (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instKill(instKill),
    .instCls(instCls), .rs1Idx(rs1Idx), .rdIdx(rdIdx), .instPcLo(instPcLo),
    .lpLabel(lpLabel), .x7Hi(x7Hi), .lpEnable(lpEnable),
    .lpExpected(lpExpected), .faultPulse(faultPulse),
    .faultCause(faultCause), .faultTval(faultTval)
  );

  task automatic issue(input bit v, input bit k, input bit en,
                       input logic [1:0] cls, input logic [4:0] rs1,
                       input logic [4:0] rd, input logic [1:0] pcl,
                       input logic [19:0] lab, input logic [19:0] x7,
                       input string tag);
    expItem_t it;
    bit fail;
    bit f = 1'b0;
    bit nx = refExp;
    @(negedge clk);
    instValid = v; instKill = k; lpEnable = en; instCls = cls;
    rs1Idx = rs1; rdIdx = rd; instPcLo = pcl; lpLabel = lab; x7Hi = x7;
    if (v && !k) begin
      if (!en) nx = 1'b0;
      else if (refExp) begin
        fail = !(cls == 2'd2 && rd == 5'd0) || (pcl != 2'd0) ||
               (lab != 20'd0 && lab != x7);
        f = fail;
        nx = fail;
      end else begin
        nx = (cls == 2'd1) && rs1 != 5'd1 && rs1 != 5'd5 && rs1 != 5'd7;
      end
    end
    refExp = nx;
    it.f = f; it.e = nx; it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #3;
    if (q.size() > 0) begin
      expItem_t it;
      it = q.pop_front();
      checks++;
      if (faultPulse !== it.f || lpExpected !== it.e) begin
        errors++;
        $display("FAIL %s: fault=%0b exp=%0b expected fault=%0b exp=%0b",
                 it.tag, faultPulse, lpExpected, it.f, it.e);
      end
      if (it.f) begin
        checks++;
        if (faultCause !== 5'd18 || faultTval !== 32'd2) begin
          errors++;
          $display("FAIL R8 %s: cause=%0d tval=%0d expected cause=18 tval=2",
                   it.tag, faultCause, faultTval);
        end
      end else begin
        checks++;
        if (faultCause !== 5'd0 || faultTval !== 32'd0) begin
          errors++;
          $display("FAIL R8 %s: cause=%0d tval=%0d expected 0 0",
                   it.tag, faultCause, faultTval);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checks++;
    if (lpExpected !== 1'b0 || faultPulse !== 1'b0) begin
      errors++;
      $display("FAIL R1: exp=%0b fault=%0b expected 0 0", lpExpected, faultPulse);
    end
    // args: valid kill en cls rs1 rd pcLo label x7
    issue(1,0,1,2'd1,5'd10,5'd0,0,20'h0,20'h0,"R2 jump x10 arms");
    issue(1,0,1,2'd0,5'd3,5'd4,0,20'h0,20'h0,"R5 plain instr faults");
    issue(1,0,1,2'd2,5'd0,5'd3,0,20'h0,20'h0,"R5 auipc rd!=0 faults");
    issue(1,0,1,2'd2,5'd0,5'd0,2'd2,20'h0,20'h0,"R6 misaligned pad faults");
    issue(1,0,1,2'd2,5'd0,5'd0,0,20'h12345,20'h54321,"R7 label mismatch");
    issue(1,0,1,2'd2,5'd0,5'd0,0,20'h12345,20'h12345,"R7 label match clears");
    issue(1,0,1,2'd1,5'd1,5'd0,0,20'h0,20'h0,"R3 return x1");
    issue(1,0,1,2'd1,5'd5,5'd0,0,20'h0,20'h0,"R3 return x5");
    issue(1,0,1,2'd1,5'd7,5'd0,0,20'h0,20'h0,"R4 guarded x7");
    issue(1,0,1,2'd2,5'd0,5'd0,2'd1,20'h777,20'h1,"R5 pad while idle no-op");
    issue(1,0,1,2'd1,5'd6,5'd1,0,20'h0,20'h0,"R2 call via x6 arms");
    issue(1,0,1,2'd2,5'd0,5'd0,0,20'h0,20'hABCDE,"R7 zero label passes");
    issue(1,1,1,2'd1,5'd9,5'd0,0,20'h0,20'h0,"R10 killed jump no arm");
    issue(1,0,1,2'd1,5'd0,5'd0,0,20'h0,20'h0,"R2 jump x0 arms");
    issue(1,1,1,2'd0,5'd0,5'd0,0,20'h0,20'h0,"R10 killed non-pad no fault");
    issue(0,0,1,2'd0,5'd3,5'd3,2'd3,20'h1,20'h2,"R11 idle no effect");
    issue(1,0,1,2'd2,5'd0,5'd0,2'd3,20'h0,20'h0,"R6 pc lo 3 faults");
    issue(1,0,0,2'd0,5'd0,5'd0,2'd3,20'h0,20'h0,"R9 disable clears no fault");
    issue(1,0,0,2'd1,5'd12,5'd0,0,20'h0,20'h0,"R9 disabled jump no arm");
    issue(1,0,1,2'd1,5'd12,5'd0,0,20'h0,20'h0,"R2 jump x12 arms");
    issue(1,0,1,2'd3,5'd0,5'd0,0,20'h0,20'h0,"R5 class 3 faults");
    issue(1,0,1,2'd1,5'd13,5'd0,0,20'h0,20'h0,"R5 jump while armed faults");
    issue(1,0,1,2'd2,5'd0,5'd0,0,20'hFFFFF,20'hFFFFF,"R7 max label match");
    issue(0,0,1,2'd0,5'd0,5'd0,0,20'h0,20'h0,"R11 idle tail");
    issue(0,0,1,2'd0,5'd0,5'd0,0,20'h0,20'h0,"R11 idle tail");
    repeat (3) @(posedge clk);
    #4;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule